// File: doc/BRIEF.md
# Segment PIN Access Checker

This block decides whether a host may read a protected memory segment, write it, or edit its management unit. It holds three validated-index registers, one per access class (read, write, edit). An outside cipher and comparator check a PIN that the host submits. When that check reports a match, the index of the PIN slot that the host selected is captured into the register for the class named. Each register keeps its value until reset.

For each access request, the block is given the segment's control bits, the PIN index stored for that segment, the access type and the address span. The block compares the cached index for the class against the segment's stored index and applies the control-bit rule for that class. An edit also has its span checked against the boundary of one management unit. The decision appears on a registered grant output one cycle after the request. All cached indexes are zero after reset. Slot zero is the all-zero PIN that is known to everyone, so a segment bound to index zero can be opened without a prior validation.

Top module: `seg_pin_gate`

## Requirements
- R1: `decision_valid` is high exactly in the cycle after a cycle with `req_valid` high. `grant` is high only together with `decision_valid`. Both are low during reset and in the cycle after an idle cycle.
- R2: When `val_valid` and `val_match` are both high, `val_index` is captured into the register of the class given by `val_class`: 2'b00 read, 2'b01 write, 2'b10 edit. Requests from the next cycle on use the new value.
- R3: A validation with `val_match` low, or any cycle with `val_valid` low, leaves all three cached indexes unchanged.
- R4: After reset all three cached indexes are zero. A segment whose stored index is 0 is therefore granted, given its control bits, without any validation. A segment with a non-zero index is denied.
- R5: A read (`req_kind` 2'b00) is granted only if `ctrl_rd` and `ctrl_rd_pin` are both 1 and the cached read index equals `seg_index`.
- R6: A write (`req_kind` 2'b01) is granted only if `ctrl_wr` and `ctrl_wr_pin` are both 1 and the cached write index equals `seg_index`.
- R7: An edit (`req_kind` 2'b10) is granted only if `ctrl_no_edit` is 0, the span lies within one unit (R8), and the cached edit index equals `seg_index`. Read and write requests ignore the span.
- R8: An edit span lies within one unit when `req_len` is at least 1 and `req_addr + req_len - 1` does not pass the last address of the `UNIT_BYTES`-aligned unit that holds `req_addr`. With the default UNIT_BYTES=16, this means (addr mod 16) + len <= 16. A span that runs past the top of the address space is outside.
- R9: `req_kind` 2'b11 is always denied. A validation with `val_class` 2'b11 changes no cached index.
- R10: A request in the same cycle as a successful validation is decided with the index cached before that validation.
- R11: A validation for one class leaves the other two classes' cached indexes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| val_valid | input | 1 | A PIN validation result is present this cycle |
| val_class | input | 2 | Class of the validated PIN: 00 read, 01 write, 10 edit, 11 none |
| val_index | input | IDX_W (8) | PIN slot selected by the host for this validation |
| val_match | input | 1 | External comparison found the two encrypted PINs equal |
| req_valid | input | 1 | An access request is present this cycle |
| req_kind | input | 2 | Access type: 00 read, 01 write, 10 edit, 11 invalid |
| ctrl_rd | input | 1 | Segment control: reading enabled |
| ctrl_rd_pin | input | 1 | Segment control: read PIN checking in force |
| ctrl_wr | input | 1 | Segment control: writing enabled |
| ctrl_wr_pin | input | 1 | Segment control: write PIN checking in force |
| ctrl_no_edit | input | 1 | Management-unit control: editing locked |
| seg_index | input | IDX_W (8) | PIN index stored for the segment and class being accessed |
| req_addr | input | ADDR_W (8) | Start address of the access |
| req_len | input | LEN_W (5) | Length of the access in bytes |
| decision_valid | output | 1 | A decision is presented this cycle |
| grant | output | 1 | Access allowed (1) or denied (0) |

## Verification
The bench sweeps all 256 PIN indexes. Each index is validated into a rotating class, and then a request of each of the three kinds is made against that index, so that a wrong class selection or a leak between classes shows up. Every combination of each class's control bits is tried with a matching and a mismatching segment index, which separates the PIN rule from the bit rule. For edits, every start offset in a unit is crossed with every length from zero to past the unit size, at two base addresses. One base sits at the top of the address space, which exposes an off-by-one or a wrap in the boundary test. Failed validations, the unused class, the invalid access kind and a validation in the same cycle as a request show whether cached state changes only when it should.

// File: rtl/seg_pin_pkg.sv
package seg_pin_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EDIT  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  localparam int unsigned NUM_CLASSES = 3;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/seg_pin_index_bank.sv
module seg_pin_index_bank
  import seg_pin_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_ni,
  input  logic                              val_valid_i,
  input  logic [1:0]                        val_class_i,
  input  logic [IDX_W-1:0]                  val_index_i,
  input  logic                              val_match_i,
  output logic [NUM_CLASSES-1:0][IDX_W-1:0] idx_o
);
  logic [NUM_CLASSES-1:0][IDX_W-1:0] idx_q;
  logic [NUM_CLASSES-1:0][IDX_W-1:0] idx_d;
  logic [NUM_CLASSES-1:0]            load_en;
  logic                              accept;

  assign accept = val_valid_i && val_match_i;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    always_comb begin
      load_en[c] = accept && (val_class_i == 2'(c));
      idx_d[c]   = load_en[c] ? val_index_i : idx_q[c];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)         idx_q[c] <= '0;
      else if (load_en[c]) idx_q[c] <= idx_d[c];
    end

    // R2 and R11: a successful validation loads only its own class
    p_load_own_class_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      (accept && val_class_i == 2'(c)) |=> (idx_q[c] == $past(val_index_i)));
    p_other_class_kept_r11: assert property (@(posedge clk) disable iff (!rst_ni)
      (accept && val_class_i != 2'(c)) |=> $stable(idx_q[c]));
  end

  // R3: nothing changes without an accepted validation
  p_hold_on_fail_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !accept |=> $stable(idx_q));

  assign idx_o = idx_q;
endmodule

// File: rtl/seg_unit_span_check.sv
module seg_unit_span_check #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned UNIT_BYTES = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              inside_o
);
  localparam int unsigned OFF_W = $clog2(UNIT_BYTES);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] last_addr;
  logic [EXT_W-1:0] unit_end;
  logic             len_zero;

  always_comb begin
    len_zero  = (len_i == '0);
    last_addr = EXT_W'(addr_i) + EXT_W'(len_i) - EXT_W'(1);
    unit_end  = {1'b0, addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b1}}};
    inside_o  = !len_zero && (last_addr <= unit_end);
  end

  // R8: an empty span is never inside a unit
  always_comb begin
    if (len_zero) p_empty_span_outside_r8: assert (!inside_o);
  end
endmodule

// File: rtl/seg_pin_gate.sv
module seg_pin_gate
  import seg_pin_pkg::*;
#(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned UNIT_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              val_valid,
  input  logic [1:0]        val_class,
  input  logic [IDX_W-1:0]  val_index,
  input  logic              val_match,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              ctrl_rd,
  input  logic              ctrl_rd_pin,
  input  logic              ctrl_wr,
  input  logic              ctrl_wr_pin,
  input  logic              ctrl_no_edit,
  input  logic [IDX_W-1:0]  seg_index,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              decision_valid,
  output logic              grant
);
  logic                              rst_q_n;
  logic [NUM_CLASSES-1:0][IDX_W-1:0] cached_idx;
  logic                              span_inside;
  logic                              allow;
  logic                              grant_d, grant_q;
  logic                              dv_d, dv_q;
  acc_kind_e                         kind;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  seg_pin_index_bank #(.IDX_W(IDX_W)) u_bank (
    .clk         (clk),
    .rst_ni      (rst_q_n),
    .val_valid_i (val_valid),
    .val_class_i (val_class),
    .val_index_i (val_index),
    .val_match_i (val_match),
    .idx_o       (cached_idx)
  );

  seg_unit_span_check #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .UNIT_BYTES (UNIT_BYTES)
  ) u_span (
    .addr_i   (req_addr),
    .len_i    (req_len),
    .inside_o (span_inside)
  );

  assign kind = acc_kind_e'(req_kind);

  always_comb begin
    unique case (kind)
      ACC_READ:  allow = ctrl_rd && ctrl_rd_pin && (cached_idx[0] == seg_index);
      ACC_WRITE: allow = ctrl_wr && ctrl_wr_pin && (cached_idx[1] == seg_index);
      ACC_EDIT:  allow = !ctrl_no_edit && span_inside && (cached_idx[2] == seg_index);
      default:   allow = 1'b0;
    endcase
    dv_d    = req_valid;
    grant_d = req_valid && allow;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dv_q    <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      dv_q    <= dv_d;
      grant_q <= grant_d;
    end
  end

  assign decision_valid = dv_q;
  assign grant          = grant_q;

  p_idle_no_decision_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> (!decision_valid && !grant));
  p_read_bits_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_kind == 2'b00 && !(ctrl_rd && ctrl_rd_pin)) |=> !grant);
  p_write_bits_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_kind == 2'b01 && !(ctrl_wr && ctrl_wr_pin)) |=> !grant);
  p_edit_lock_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_kind == 2'b10 && (ctrl_no_edit || !span_inside)) |=> !grant);
  p_bad_kind_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_kind == 2'b11) |=> !grant);
endmodule

// File: tb/seg_pin_gate_bench.sv
`timescale 1ns/1ps
module seg_pin_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       val_valid, val_match;
  logic [1:0] val_class, req_kind;
  logic [7:0] val_index, seg_index, req_addr;
  logic       req_valid, ctrl_rd, ctrl_rd_pin, ctrl_wr, ctrl_wr_pin, ctrl_no_edit;
  logic [4:0] req_len;
  logic       decision_valid, grant;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] m_idx [3];

  always #2.5 clk = ~clk;

  seg_pin_gate u_seg_pin_gate (
    .clk(clk), .rst_n(rst_n),
    .val_valid(val_valid), .val_class(val_class), .val_index(val_index), .val_match(val_match),
    .req_valid(req_valid), .req_kind(req_kind),
    .ctrl_rd(ctrl_rd), .ctrl_rd_pin(ctrl_rd_pin), .ctrl_wr(ctrl_wr), .ctrl_wr_pin(ctrl_wr_pin),
    .ctrl_no_edit(ctrl_no_edit), .seg_index(seg_index), .req_addr(req_addr), .req_len(req_len),
    .decision_valid(decision_valid), .grant(grant)
  );

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic logic model(logic [1:0] k, logic rd, logic rdp, logic wr, logic wrp,
                                 logic ne, logic [7:0] seg, int addr, int len);
    case (k)
      2'b00: return rd && rdp && (m_idx[0] == seg);
      2'b01: return wr && wrp && (m_idx[1] == seg);
      2'b10: return !ne && (len >= 1) && ((addr % 16) + len <= 16) && (m_idx[2] == seg);
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_req(string tag, logic [1:0] k, logic rd, logic rdp, logic wr, logic wrp,
                        logic ne, logic [7:0] seg, int addr, int len);
    logic e;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; ctrl_rd = rd; ctrl_rd_pin = rdp; ctrl_wr = wr;
    ctrl_wr_pin = wrp; ctrl_no_edit = ne; seg_index = seg; req_addr = 8'(addr); req_len = 5'(len);
    e = model(k, rd, rdp, wr, wrp, ne, seg, addr, len);
    @(negedge clk);
    chk({tag, " valid"}, decision_valid, 1'b1);
    chk(tag, grant, e);
    req_valid = 1'b0;
  endtask

  task automatic do_val(logic [1:0] cls, logic [7:0] idx, logic ok, logic vv);
    @(negedge clk);
    val_valid = vv; val_class = cls; val_index = idx; val_match = ok;
    @(negedge clk);
    val_valid = 1'b0; val_match = 1'b0;
    if (vv && ok && cls != 2'b11) m_idx[cls] = idx;
  endtask

  task automatic req_all(string tag, logic [7:0] seg);
    do_req({tag, " read"},  2'b00, 1, 1, 0, 0, 1, seg, 0, 1);
    do_req({tag, " write"}, 2'b01, 0, 0, 1, 1, 1, seg, 0, 1);
    do_req({tag, " edit"},  2'b10, 0, 0, 0, 0, 0, seg, 0, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; val_valid = 0; val_match = 0; val_class = 0; val_index = 0;
    req_valid = 0; req_kind = 0; ctrl_rd = 0; ctrl_rd_pin = 0; ctrl_wr = 0; ctrl_wr_pin = 0;
    ctrl_no_edit = 1; seg_index = 0; req_addr = 0; req_len = 0;
    for (int c = 0; c < 3; c++) m_idx[c] = 8'd0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", decision_valid, 1'b0);
    chk("R1 reset grant", grant, 1'b0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle valid", decision_valid, 1'b0);

    // R4: zero index opens without validation, non-zero does not
    req_all("R4 seg0", 8'd0);
    req_all("R4 seg5", 8'd5);

    // R5 / R6 / R7: control-bit combinations with matching and mismatching index
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 2; s++) begin
        do_req("R5 read bits", 2'b00, b[0], b[1], 1, 1, 0, 8'(s), 0, 1);
        do_req("R6 write bits", 2'b01, 1, 1, b[0], b[1], 0, 8'(s), 0, 1);
      end
    end
    for (int s = 0; s < 2; s++) begin
      do_req("R7 edit unlocked", 2'b10, 0, 0, 0, 0, 0, 8'(s), 3, 4);
      do_req("R7 edit locked", 2'b10, 1, 1, 1, 1, 1, 8'(s), 3, 4);
    end
    // R7: read and write ignore the span
    do_req("R7 read span ignored", 2'b00, 1, 1, 0, 0, 0, 8'd0, 15, 0);
    do_req("R7 write span ignored", 2'b01, 0, 0, 1, 1, 0, 8'd0, 250, 20);

    // R2 / R11: sweep every index through rotating classes
    for (int i = 0; i < 256; i++) begin
      do_val(2'(i % 3), 8'(i), 1'b1, 1'b1);
      req_all("R2 R11 sweep", 8'(i));
    end

    // R3: failed or absent validations leave state alone
    do_val(2'b00, 8'd77, 1'b0, 1'b1);
    do_val(2'b01, 8'd78, 1'b1, 1'b0);
    req_all("R3 hold old", m_idx[0]);
    do_req("R3 read new denied", 2'b00, 1, 1, 0, 0, 0, 8'd77, 0, 1);
    do_req("R3 write new denied", 2'b01, 0, 0, 1, 1, 0, 8'd78, 0, 1);

    // R9: unused class and invalid kind
    do_val(2'b11, 8'd99, 1'b1, 1'b1);
    req_all("R9 class none ignored", 8'd99);
    for (int c = 0; c < 3; c++)
      do_req("R9 kind invalid", 2'b11, 1, 1, 1, 1, 0, m_idx[c], 0, 1);

    // R8: boundary sweep of edit spans
    do_val(2'b10, 8'd42, 1'b1, 1'b1);
    for (int bi = 0; bi < 2; bi++) begin
      for (int off = 0; off < 16; off++) begin
        for (int len = 0; len < 18; len++) begin
          do_req("R8 span", 2'b10, 0, 0, 0, 0, 0, 8'd42, (bi == 0 ? 8'h30 : 8'hF0) + off, len);
        end
      end
    end

    // R10: request in the validation cycle uses the previous index
    @(negedge clk);
    val_valid = 1; val_match = 1; val_class = 2'b00; val_index = 8'd200;
    req_valid = 1; req_kind = 2'b00; ctrl_rd = 1; ctrl_rd_pin = 1; seg_index = m_idx[0];
    @(negedge clk);
    chk("R10 old index granted", grant, 1'b1);
    val_valid = 0; val_match = 0;
    seg_index = 8'd200;
    m_idx[0] = 8'd200;
    @(negedge clk);
    chk("R10 new index granted after", grant, 1'b1);
    req_valid = 0;
    @(negedge clk);
    chk("R1 idle after request", decision_valid, 1'b0);
    chk("R1 idle grant low", grant, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule